// File: doc/BRIEF.md
# In-Order Retirement Queue with Deferred Faults

This block lets execution units finish work in any order while the architectural register file only ever sees results in program order. Each instruction claims a slot in a circular eight-slot queue when it is dispatched, and dispatch order is program order. When an execution unit finishes, it writes the result value into that slot, or marks the slot as faulted. The oldest slot leaves the queue only once it has finished. A clean result then drives the register-file write port. A fault is reported at that same point, and never earlier.

A fault reported at the oldest slot discards that slot and every younger one in a single cycle. Results that younger instructions have already produced are therefore never written. While results wait to retire, operand reads can bypass the register file through a lookup port. The port searches the queue for the youngest in-flight producer of the requested register and returns its value, or reports that this producer has not finished yet.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready`=1, `ret_valid`=0, `rf_we`=0, `fault_valid`=0 and `rd_hit`=0 for any register.
- R2: The tag returned on `disp_tag` is the slot index. Successive dispatches get consecutive indices modulo 8, and eight slots may be occupied at once.
- R3: A finished result is not written to the register file while any older slot is unfinished. The write happens only when its slot is the oldest.
- R4: At most one slot retires per cycle, and retirement follows dispatch order whatever order completion came in. A clean retirement drives `rf_we`=1 with that slot's register number and value.
- R5: A slot dispatched with `disp_dst_en`=0 retires with `ret_valid`=1 and `rf_we`=0.
- R6: A fault is reported only when the faulting slot is the oldest. In that cycle `fault_valid`=1, `fault_pc` carries the PC the slot was dispatched with, and `rf_we`=0.
- R7: In the cycle after a fault report the queue is empty, and no younger finished result is ever written. The next dispatch receives the faulting slot's tag.
- R8: The lookup port reports the youngest occupied slot whose destination matches `rd_reg`. `rd_ready` and `rd_value` come from that slot, and `rd_ready`=0 if it has not finished, even when an older producer of the same register has finished.
- R9: The lookup reports `rd_hit`=0 for a register with no occupied producing slot. Retired and discarded slots are not matched.
- R10: A completion whose tag names a free slot is ignored. It does not mark a slot that is later dispatched into that index as finished.
- R11: A dispatch attempted while eight slots are occupied, or in a cycle with `fault_valid`=1, is dropped: `disp_ready`=0 and no slot is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dst_en | input | 1 | Instruction writes a register |
| disp_dst | input | 5 | Destination register number |
| disp_pc | input | 32 | PC of the dispatched instruction |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_tag | output | 3 | Slot index given to the dispatch |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | 3 | Slot index being completed |
| cmp_value | input | 32 | Result value |
| cmp_fault | input | 1 | Instruction faulted |
| rd_reg | input | 5 | Register number to look up |
| rd_hit | output | 1 | An occupied slot produces `rd_reg` |
| rd_ready | output | 1 | That youngest producer has finished |
| rd_value | output | 32 | Its result value |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | 5 | Register file write address |
| rf_data | output | 32 | Register file write data |
| ret_valid | output | 1 | A slot retires cleanly this cycle |
| fault_valid | output | 1 | Fault committed this cycle |
| fault_pc | output | 32 | PC of the faulting instruction |

## Verification
`disp_ready`, `disp_tag` and the lookup outputs are combinational, so they are due in the same cycle as their inputs. Retirement outputs follow the completing clock edge by exactly one cycle, and the slot is freed, or the queue flushed, at the next edge. The bench drives every input on the falling edge and samples one nanosecond later, before the next rising edge. Each retirement or fault check therefore lands in the cycle right after the completion that enabled it, and each following-cycle check lands after the freeing edge.

// File: rtl/retq_pkg.sv
package retq_pkg;

    localparam int unsigned Q_DEPTH = 8;
    localparam int unsigned Q_AW    = 5;
    localparam int unsigned Q_DW    = 32;
    localparam int unsigned Q_PCW   = 32;

    // one queue slot
    typedef struct packed {
        logic              valid;
        logic              done;
        logic              fault;
        logic              dst_en;
        logic [Q_AW-1:0]   dst;
        logic [Q_DW-1:0]   value;
        logic [Q_PCW-1:0]  pc;
    } slot_t;

    // bypass answer
    typedef struct packed {
        logic            hit;
        logic            ready;
        logic [Q_DW-1:0] value;
    } fwd_t;

    typedef enum logic [1:0] {
        HD_IDLE   = 2'd0,
        HD_RETIRE = 2'd1,
        HD_FAULT  = 2'd2
    } head_act_e;

    function automatic head_act_e classify_head(input slot_t s);
        if (!(s.valid && s.done)) return HD_IDLE;
        return s.fault ? HD_FAULT : HD_RETIRE;
    endfunction

endpackage

// File: rtl/retq_ptr.sv
module retq_ptr #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic          full,
    output logic          empty
);
    logic [PW-1:0] head_q, tail_q;
    logic          full_q;
    logic [PW-1:0] tail_inc;

    assign tail_inc = tail_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            full_q <= 1'b0;
        end else if (flush) begin
            tail_q <= head_q;
            full_q <= 1'b0;
        end else begin
            if (push) tail_q <= tail_inc;
            if (pop)  head_q <= head_q + PW'(1);
            if (push && !pop)      full_q <= (tail_inc == head_q);
            else if (pop && !push) full_q <= 1'b0;
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign full  = full_q;
    assign empty = (head_q == tail_q) && !full_q;

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (head_q == tail_q) && !full_q);

    p_pop_steps_head_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |=> head_q == $past(head_q) + PW'(1));

    p_full_holds_tail_r11: assert property (@(posedge clk) disable iff (rst)
        (full_q && !flush) |=> $stable(tail_q));

endmodule

// File: rtl/retq_lookup.sv
module retq_lookup
    import retq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slots [DEPTH],
    input  logic [PW-1:0]    head,
    input  logic [Q_AW-1:0]  rd_reg,
    output fwd_t             fwd
);
    // walk from oldest to youngest; the last match is the youngest
    always_comb begin
        logic [PW-1:0] idx;
        fwd = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (slots[idx].valid && slots[idx].dst_en && slots[idx].dst == rd_reg) begin
                fwd.hit   = 1'b1;
                fwd.ready = slots[idx].done;
                fwd.value = slots[idx].value;
            end
        end
    end

    p_ready_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
        fwd.ready |-> fwd.hit);

endmodule

// File: rtl/retq_commit.sv
module retq_commit
    import retq_pkg::*;
(
    input  slot_t             head_slot,
    output head_act_e         act,
    output logic              rf_we,
    output logic [Q_AW-1:0]   rf_addr,
    output logic [Q_DW-1:0]   rf_data,
    output logic              ret_valid,
    output logic              fault_valid,
    output logic [Q_PCW-1:0]  fault_pc
);
    always_comb begin
        act         = classify_head(head_slot);
        ret_valid   = (act == HD_RETIRE);
        fault_valid = (act == HD_FAULT);
        rf_we       = ret_valid && head_slot.dst_en;
        rf_addr     = head_slot.dst;
        rf_data     = head_slot.value;
        fault_pc    = fault_valid ? head_slot.pc : '0;
    end

endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import retq_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic              disp_dst_en,
    input  logic [Q_AW-1:0]   disp_dst,
    input  logic [Q_PCW-1:0]  disp_pc,
    output logic              disp_ready,
    output logic [PW-1:0]     disp_tag,
    input  logic              cmp_valid,
    input  logic [PW-1:0]     cmp_tag,
    input  logic [Q_DW-1:0]   cmp_value,
    input  logic              cmp_fault,
    input  logic [Q_AW-1:0]   rd_reg,
    output logic              rd_hit,
    output logic              rd_ready,
    output logic [Q_DW-1:0]   rd_value,
    output logic              rf_we,
    output logic [Q_AW-1:0]   rf_addr,
    output logic [Q_DW-1:0]   rf_data,
    output logic              ret_valid,
    output logic              fault_valid,
    output logic [Q_PCW-1:0]  fault_pc
);
    slot_t         slots_q [DEPTH];
    logic [PW-1:0] head, tail;
    logic          full, empty;
    logic          push, pop, flush;
    head_act_e     act;
    fwd_t          fwd;

    retq_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    retq_commit u_commit (
        .head_slot(slots_q[head]), .act(act),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .ret_valid(ret_valid), .fault_valid(fault_valid), .fault_pc(fault_pc)
    );

    retq_lookup #(.DEPTH(DEPTH)) u_look (
        .clk(clk), .rst(rst), .slots(slots_q), .head(head),
        .rd_reg(rd_reg), .fwd(fwd)
    );

    assign pop        = (act == HD_RETIRE);
    assign flush      = (act == HD_FAULT);
    assign disp_ready = !full && !flush;
    assign disp_tag   = tail;
    assign push       = disp_valid && disp_ready;

    assign rd_hit   = fwd.hit;
    assign rd_ready = fwd.ready;
    assign rd_value = fwd.value;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else begin
            if (pop) slots_q[head] <= '0;
            if (cmp_valid && slots_q[cmp_tag].valid && !slots_q[cmp_tag].done) begin
                slots_q[cmp_tag].done  <= 1'b1;
                slots_q[cmp_tag].fault <= cmp_fault;
                slots_q[cmp_tag].value <= cmp_value;
            end
            if (push) begin
                slots_q[tail] <= '{valid: 1'b1, done: 1'b0, fault: 1'b0,
                                   dst_en: disp_dst_en, dst: disp_dst,
                                   value: '0, pc: disp_pc};
            end
        end
    end

    p_after_fault_idle_r7: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !ret_valid && !fault_valid && empty);

    p_write_frees_slot_r4: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !slots_q[$past(head)].valid);

endmodule

// File: tb/sim_retire_queue.sv
`timescale 1ns/1ps
module sim_retire_queue;
    logic        clk = 1'b0;
    logic        rst;
    logic        disp_valid, disp_dst_en;
    logic [4:0]  disp_dst;
    logic [31:0] disp_pc;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        cmp_valid, cmp_fault;
    logic [2:0]  cmp_tag;
    logic [31:0] cmp_value;
    logic [4:0]  rd_reg;
    logic        rd_hit, rd_ready;
    logic [31:0] rd_value;
    logic        rf_we;
    logic [4:0]  rf_addr;
    logic [31:0] rf_data;
    logic        ret_valid, fault_valid;
    logic [31:0] fault_pc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    retire_queue u0 (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_dst_en(disp_dst_en), .disp_dst(disp_dst),
        .disp_pc(disp_pc), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
        .cmp_fault(cmp_fault), .rd_reg(rd_reg), .rd_hit(rd_hit),
        .rd_ready(rd_ready), .rd_value(rd_value), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_data(rf_data), .ret_valid(ret_valid),
        .fault_valid(fault_valid), .fault_pc(fault_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        disp_valid = 0; disp_dst_en = 0; disp_dst = '0; disp_pc = '0;
        cmp_valid = 0; cmp_tag = '0; cmp_value = '0; cmp_fault = 0;
    endtask

    task automatic tick();
        @(negedge clk); clear_in(); #1;
    endtask

    task automatic do_disp(input logic en, input logic [4:0] d, input logic [31:0] pc,
                           input logic [2:0] exp_tag, input string req);
        @(negedge clk); clear_in();
        disp_valid = 1; disp_dst_en = en; disp_dst = d; disp_pc = pc; #1;
        chk(disp_ready === 1'b1, req, 32'(disp_ready), 1);
        chk(disp_tag === exp_tag, req, 32'(disp_tag), 32'(exp_tag));
    endtask

    task automatic do_cmp(input logic [2:0] t, input logic [31:0] v, input logic f);
        @(negedge clk); clear_in();
        cmp_valid = 1; cmp_tag = t; cmp_value = v; cmp_fault = f; #1;
    endtask

    task automatic t_reset();
        tick(); rd_reg = 5'd3; #1;
        chk(disp_ready === 1'b1, "R1 ready", 32'(disp_ready), 1);
        chk(ret_valid === 1'b0, "R1 ret", 32'(ret_valid), 0);
        chk(rf_we === 1'b0, "R1 we", 32'(rf_we), 0);
        chk(fault_valid === 1'b0, "R1 fault", 32'(fault_valid), 0);
        chk(rd_hit === 1'b0, "R1 hit", 32'(rd_hit), 0);
    endtask

    // tags 0..2; out-of-order completion, in-order retirement
    task automatic t_order();
        do_disp(1, 5'd3, 32'h100, 3'd0, "R2 tag0");
        do_disp(0, 5'd0, 32'h104, 3'd1, "R2 tag1");
        do_disp(1, 5'd4, 32'h108, 3'd2, "R2 tag2");
        do_cmp(3'd2, 32'h33, 0);
        tick(); rd_reg = 5'd4; #1;
        chk(ret_valid === 1'b0 && rf_we === 1'b0, "R3 young waits", 32'(rf_we), 0);
        chk(rd_hit && rd_ready && rd_value === 32'h33, "R8 bypass done", rd_value, 32'h33);
        do_cmp(3'd0, 32'hAA, 0);
        tick();
        chk(rf_we === 1'b1 && rf_addr === 5'd3, "R4 first addr", 32'(rf_addr), 3);
        chk(rf_data === 32'hAA, "R4 first data", rf_data, 32'hAA);
        tick();
        chk(ret_valid === 1'b0, "R3 head not done", 32'(ret_valid), 0);
        do_cmp(3'd1, 32'h0, 0);
        tick();
        chk(ret_valid === 1'b1 && rf_we === 1'b0, "R5 no-dest retire", 32'({ret_valid, rf_we}), 2);
        tick();
        chk(rf_we === 1'b1 && rf_addr === 5'd4 && rf_data === 32'h33, "R4 third", rf_data, 32'h33);
        tick();
        chk(ret_valid === 1'b0 && disp_ready === 1'b1, "R4 drained", 32'(ret_valid), 0);
    endtask

    // tags 3..5; two producers of r5
    task automatic t_newest();
        do_disp(1, 5'd5, 32'h200, 3'd3, "R2 tag3");
        do_disp(1, 5'd5, 32'h204, 3'd4, "R2 tag4");
        do_disp(1, 5'd6, 32'h208, 3'd5, "R2 tag5");
        do_cmp(3'd3, 32'h111, 0);
        tick(); rd_reg = 5'd5; #1;
        chk(rd_hit === 1'b1 && rd_ready === 1'b0, "R8 youngest not ready", 32'(rd_ready), 0);
        rd_reg = 5'd7; #1;
        chk(rd_hit === 1'b0, "R9 no producer", 32'(rd_hit), 0);
        do_cmp(3'd4, 32'h222, 0);
        tick(); rd_reg = 5'd5; #1;
        chk(rd_hit && rd_ready && rd_value === 32'h222, "R8 youngest value", rd_value, 32'h222);
        do_cmp(3'd5, 32'h333, 0);
        tick(); tick(); rd_reg = 5'd5; #1;
        chk(rd_hit === 1'b0, "R9 retired r5", 32'(rd_hit), 0);
        rd_reg = 5'd6; #1;
        chk(rd_hit === 1'b0, "R9 retired r6", 32'(rd_hit), 0);
    endtask

    // tags 6,7,0; tag6 faults after tag7 finished
    task automatic t_fault();
        do_disp(1, 5'd1, 32'h300, 3'd6, "R2 tag6");
        do_disp(1, 5'd2, 32'h304, 3'd7, "R2 tag7");
        do_disp(1, 5'd9, 32'h308, 3'd0, "R2 wrap");
        do_cmp(3'd7, 32'h77, 0);
        tick();
        chk(ret_valid === 1'b0 && rf_we === 1'b0 && fault_valid === 1'b0, "R6 younger held", 32'(rf_we), 0);
        do_cmp(3'd6, 32'h0, 1);
        @(negedge clk); clear_in();
        disp_valid = 1; disp_dst_en = 1; disp_dst = 5'd20; disp_pc = 32'h400; #1;
        chk(fault_valid === 1'b1, "R6 fault raised", 32'(fault_valid), 1);
        chk(fault_pc === 32'h300, "R6 fault pc", fault_pc, 32'h300);
        chk(rf_we === 1'b0, "R6 no write", 32'(rf_we), 0);
        chk(disp_ready === 1'b0, "R11 blocked on fault", 32'(disp_ready), 0);
        tick(); rd_reg = 5'd2; #1;
        chk(fault_valid === 1'b0 && ret_valid === 1'b0 && rf_we === 1'b0, "R7 flushed", 32'(rf_we), 0);
        chk(rd_hit === 1'b0, "R7 younger gone", 32'(rd_hit), 0);
        rd_reg = 5'd20; #1;
        chk(rd_hit === 1'b0, "R11 fault-cycle dispatch dropped", 32'(rd_hit), 0);
        do_cmp(3'd0, 32'hDEAD, 0);
        do_disp(1, 5'd10, 32'h500, 3'd6, "R7 tail reset");
        do_cmp(3'd6, 32'h66, 0);
        tick();
        chk(rf_we === 1'b1 && rf_addr === 5'd10 && rf_data === 32'h66, "R7 resume", rf_data, 32'h66);
    endtask

    // fill all eight starting at tag7, drain with reversed completion
    task automatic t_full();
        for (int k = 0; k < 8; k++)
            do_disp(1, 5'(k + 1), 32'h600 + 32'(k), 3'((7 + k) % 8), "R2 fill");
        tick(); rd_reg = 5'd2; #1;
        chk(disp_ready === 1'b0, "R11 full", 32'(disp_ready), 0);
        chk(rd_hit === 1'b1 && rd_ready === 1'b0, "R10 stale completion ignored", 32'(rd_ready), 0);
        @(negedge clk); clear_in();
        disp_valid = 1; disp_dst_en = 1; disp_dst = 5'd25; disp_pc = 32'h999; #1;
        chk(disp_ready === 1'b0, "R11 full reject", 32'(disp_ready), 0);
        tick(); rd_reg = 5'd25; #1;
        chk(rd_hit === 1'b0, "R11 nothing claimed", 32'(rd_hit), 0);
        for (int k = 7; k >= 0; k--)
            do_cmp(3'((7 + k) % 8), 32'(k * 16 + 5), 0);
        for (int k = 0; k < 8; k++) begin
            tick();
            chk(rf_we === 1'b1 && rf_addr === 5'(k + 1), "R4 program order", 32'(rf_addr), 32'(k + 1));
            chk(rf_data === 32'(k * 16 + 5), "R4 order data", rf_data, 32'(k * 16 + 5));
        end
        tick();
        chk(ret_valid === 1'b0 && disp_ready === 1'b1, "R2 empty again", 32'(disp_ready), 1);
    endtask

    initial begin
        rst = 1; rd_reg = '0; clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_order();
        t_newest();
        t_fault();
        t_full();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule